// File: doc/BRIEF.md
# Interleaved Capture and Compare Buffer

This block sits behind a receiver built from eight time-interleaved converters. On every beat of the slow clock it takes one 4-bit sample from each converter lane. It puts the lanes back into symbol order and works on a 1024-symbol store in one of two ways. In capture mode it records the incoming symbols. In compare mode it checks each incoming symbol against the value already held at the same position.

A run starts with an arm pulse, and the mode is sampled at that pulse. Capture fills the store exactly once, raises a full flag and then stops. Compare runs through the store over and over, wrapping at the end, until a disarm pulse stops it. While it runs, it counts mismatching symbols in a saturating counter and latches the position of the first mismatch. A typical sequence captures a known training pattern first, then re-arms in compare mode and measures errors against it. A registered read port returns any stored symbol.

Top module: `sym_capture_buffer`

## Requirements
- R1: After synchronous reset, busy, full and first_err_valid are 0 and err_count is 0.
- R2: Lane k occupies bits [4k+3:4k] of lane_data. In the n-th accepted beat of a capture, lane k is stored at symbol address 8n+k. rd_data shows the symbol at rd_addr one clock after rd_addr is sampled.
- R3: A capture ends after 128 accepted beats (1024 symbols). One clock after the last beat, full is 1 and busy is 0, and beats presented after that leave the store unchanged.
- R4: A cycle with lane_valid low is not a beat. The symbol address does not advance and nothing is written or compared.
- R5: In compare mode, each accepted beat raises err_count by the number of lanes whose sample differs from the stored symbol at its address. The new count is visible one clock later.
- R6: In compare mode the beat address wraps from the last row back to symbol 0, and comparison continues until disarm. After disarm, busy is 0 and further beats leave err_count unchanged.
- R7: first_err_valid rises with the first mismatch after arm. first_err_addr then holds that symbol's address (the lowest mismatching lane of the earliest mismatching beat) and stays unchanged until the next arm.
- R8: err_count saturates at its all-ones value instead of wrapping. Its width is a parameter.
- R9: An arm pulse clears err_count, first_err_valid and full and restarts at symbol 0. Lane data presented in the arm cycle is ignored.
- R10: The mode is taken from mode_cmp (1 = compare, 0 = capture) in the arm cycle. Changing mode_cmp during a run has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slow (beat) clock |
| rst | input | 1 | Synchronous active-high reset |
| lane_data | input | 32 | Eight 4-bit lane samples, lane k at bits [4k+3:4k] |
| lane_valid | input | 1 | Current cycle carries a beat |
| mode_cmp | input | 1 | Mode for the next arm: 1 compare, 0 capture |
| arm | input | 1 | Start a run, clearing results |
| disarm | input | 1 | Stop the current run |
| rd_addr | input | 10 | Symbol address for the read port |
| rd_data | output | 4 | Registered symbol at rd_addr |
| busy | output | 1 | A run is in progress |
| full | output | 1 | Capture has completed 1024 symbols |
| err_count | output | CNT_W | Saturating mismatch count |
| first_err_valid | output | 1 | A mismatch has been seen since arm |
| first_err_addr | output | 10 | Symbol address of the first mismatch |

## Verification
Every result in this block lags its cause by exactly one register. err_count, first_err_valid, first_err_addr, full and busy change at the clock edge that accepts the beat or the arm/disarm pulse, and rd_data changes at the edge that samples rd_addr. The bench drives each input at a falling edge and samples the outputs at the next falling edge, so exactly one rising edge lies between stimulus and check. A second instance with a 4-bit counter receives the same stimulus, which brings saturation within reach of a short run.

// File: rtl/symcap_pkg.sv
package symcap_pkg;
    localparam int LANES  = 8;
    localparam int SW     = 4;
    localparam int DEPTH  = 1024;
    localparam int ROWS   = DEPTH / LANES;
    localparam int ROW_W  = $clog2(ROWS);
    localparam int LANE_W = $clog2(LANES);
    localparam int ADDR_W = ROW_W + LANE_W;
    localparam int BUS_W  = LANES * SW;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_CAPT = 2'd1,
        ST_CMP  = 2'd2
    } run_st_t;

    typedef struct packed {
        logic              valid;
        logic [ADDR_W-1:0] addr;
    } first_err_t;

    function automatic logic [LANE_W:0] popcnt(input logic [LANES-1:0] v);
        logic [LANE_W:0] n;
        n = '0;
        for (int i = 0; i < LANES; i++) begin
            n = n + {{LANE_W{1'b0}}, v[i]};
        end
        return n;
    endfunction

    function automatic logic [LANE_W-1:0] lowest_set(input logic [LANES-1:0] v);
        logic [LANE_W-1:0] idx;
        idx = '0;
        for (int i = LANES - 1; i >= 0; i--) begin
            if (v[i]) idx = LANE_W'(i);
        end
        return idx;
    endfunction
endpackage

// File: rtl/sym_bank.sv
module sym_bank
    import symcap_pkg::*;
(
    input  logic             clk,
    input  logic             we,
    input  logic [ROW_W-1:0] wr_row,
    input  logic [SW-1:0]    wr_sym,
    input  logic [ROW_W-1:0] cmp_row,
    output logic [SW-1:0]    cmp_sym,
    input  logic [ROW_W-1:0] rd_row,
    output logic [SW-1:0]    rd_sym
);
    logic [SW-1:0] store [ROWS];

    always_ff @(posedge clk) begin
        if (we) store[wr_row] <= wr_sym;
    end

    assign cmp_sym = store[cmp_row];
    assign rd_sym  = store[rd_row];
endmodule

// File: rtl/sym_seq_ctrl.sv
module sym_seq_ctrl
    import symcap_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             arm,
    input  logic             disarm,
    input  logic             mode_cmp,
    input  logic             lane_valid,
    output logic             wr_en,
    output logic             cmp_en,
    output logic [ROW_W-1:0] row,
    output logic             busy,
    output logic             full
);
    run_st_t st;
    logic    accept;

    assign accept = lane_valid && !arm && !disarm && (st != ST_IDLE);
    assign wr_en  = accept && (st == ST_CAPT);
    assign cmp_en = accept && (st == ST_CMP);
    assign busy   = (st != ST_IDLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            st   <= ST_IDLE;
            row  <= '0;
            full <= 1'b0;
        end else if (arm) begin
            st   <= mode_cmp ? ST_CMP : ST_CAPT;
            row  <= '0;
            full <= 1'b0;
        end else if (disarm) begin
            st <= ST_IDLE;
        end else if (accept) begin
            row <= row + 1'b1;
            if (st == ST_CAPT && row == ROW_W'(ROWS - 1)) begin
                st   <= ST_IDLE;
                full <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/sym_err_track.sv
module sym_err_track
    import symcap_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             cmp_en,
    input  logic [LANES-1:0] mism,
    input  logic [ROW_W-1:0] row,
    output logic [CNT_W-1:0] count,
    output first_err_t       first
);
    logic [CNT_W:0]   sum;
    logic [CNT_W-1:0] count_nx;

    assign sum      = {1'b0, count} + (CNT_W + 1)'(popcnt(mism));
    assign count_nx = sum[CNT_W] ? {CNT_W{1'b1}} : sum[CNT_W-1:0];

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            count <= '0;
            first <= '0;
        end else if (cmp_en) begin
            count <= count_nx;
            if (!first.valid && (|mism)) begin
                first.valid <= 1'b1;
                first.addr  <= {row, lowest_set(mism)};
            end
        end
    end
endmodule

// File: rtl/sym_capture_buffer.sv
module sym_capture_buffer
    import symcap_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [BUS_W-1:0]  lane_data,
    input  logic              lane_valid,
    input  logic              mode_cmp,
    input  logic              arm,
    input  logic              disarm,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [SW-1:0]     rd_data,
    output logic              busy,
    output logic              full,
    output logic [CNT_W-1:0]  err_count,
    output logic              first_err_valid,
    output logic [ADDR_W-1:0] first_err_addr
);
    logic             wr_en;
    logic             cmp_en;
    logic [ROW_W-1:0] row;
    logic [LANES-1:0] mism;
    logic [SW-1:0]    rd_bank [LANES];
    first_err_t       first;

    sym_seq_ctrl u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .arm        (arm),
        .disarm     (disarm),
        .mode_cmp   (mode_cmp),
        .lane_valid (lane_valid),
        .wr_en      (wr_en),
        .cmp_en     (cmp_en),
        .row        (row),
        .busy       (busy),
        .full       (full)
    );

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        logic [SW-1:0] cmp_sym;

        sym_bank u_bank (
            .clk     (clk),
            .we      (wr_en),
            .wr_row  (row),
            .wr_sym  (lane_data[k*SW +: SW]),
            .cmp_row (row),
            .cmp_sym (cmp_sym),
            .rd_row  (rd_addr[ADDR_W-1:LANE_W]),
            .rd_sym  (rd_bank[k])
        );

        assign mism[k] = (cmp_sym != lane_data[k*SW +: SW]);
    end

    sym_err_track #(.CNT_W(CNT_W)) u_err (
        .clk    (clk),
        .rst    (rst),
        .clr    (arm),
        .cmp_en (cmp_en),
        .mism   (mism),
        .row    (row),
        .count  (err_count),
        .first  (first)
    );

    assign first_err_valid = first.valid;
    assign first_err_addr  = first.addr;

    always_ff @(posedge clk) begin
        if (rst) rd_data <= '0;
        else     rd_data <= rd_bank[rd_addr[LANE_W-1:0]];
    end
endmodule

// File: rtl/sym_capture_buffer_chk.sv
module sym_capture_buffer_chk
    import symcap_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              arm,
    input logic              busy,
    input logic              full,
    input logic [CNT_W-1:0]  err_count,
    input logic              first_err_valid,
    input logic [ADDR_W-1:0] first_err_addr
);
    a_r1_reset_state: assert property (@(posedge clk)
        rst |=> (!busy && !full && err_count == '0 && !first_err_valid));

    a_r9_arm_clears: assert property (@(posedge clk) disable iff (rst)
        arm |=> (busy && !full && err_count == '0 && !first_err_valid));

    a_r7_first_held: assert property (@(posedge clk) disable iff (rst)
        (first_err_valid && !arm) |=> (first_err_valid && $stable(first_err_addr)));

    a_r8_no_wrap: assert property (@(posedge clk) disable iff (rst)
        !arm |=> (err_count >= $past(err_count)));

    a_r6_idle_hold: assert property (@(posedge clk) disable iff (rst)
        (!busy && !arm) |=> $stable(err_count));

    a_r3_full_idle: assert property (@(posedge clk) disable iff (rst)
        full |-> !busy);
endmodule

bind sym_capture_buffer sym_capture_buffer_chk #(.CNT_W(CNT_W)) u_chk (
    .clk             (clk),
    .rst             (rst),
    .arm             (arm),
    .busy            (busy),
    .full            (full),
    .err_count       (err_count),
    .first_err_valid (first_err_valid),
    .first_err_addr  (first_err_addr)
);

// File: tb/sim_sym_capture_buffer.sv
module sim_sym_capture_buffer;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] lane_data = '0;
    logic        lane_valid = 1'b0;
    logic        mode_cmp = 1'b0;
    logic        arm = 1'b0;
    logic        disarm = 1'b0;
    logic [9:0]  rd_addr = '0;

    logic [3:0]  rd_data, s_rd_data;
    logic        busy, full, s_busy, s_full;
    logic [31:0] err_count;
    logic [3:0]  s_err;
    logic        fev, s_fev;
    logic [9:0]  fea, s_fea;

    int total = 0;
    int bad   = 0;
    int cum   = 0;
    logic [31:0] msk;
    logic [3:0]  inc;

    // Each entry: {xor mask applied to the stored beat, expected mismatch increment}
    localparam logic [35:0] VEC [0:7] = '{
        36'h00000000_0, 36'h00000000_0, 36'h0000F000_1, 36'hFFFFFFFF_8,
        36'h10101010_4, 36'h00000001_1, 36'h00000000_0, 36'h80000000_1
    };

    always #5 clk = ~clk;

    sym_capture_buffer u0 (
        .clk(clk), .rst(rst), .lane_data(lane_data), .lane_valid(lane_valid),
        .mode_cmp(mode_cmp), .arm(arm), .disarm(disarm), .rd_addr(rd_addr),
        .rd_data(rd_data), .busy(busy), .full(full), .err_count(err_count),
        .first_err_valid(fev), .first_err_addr(fea)
    );

    sym_capture_buffer #(.CNT_W(4)) u1 (
        .clk(clk), .rst(rst), .lane_data(lane_data), .lane_valid(lane_valid),
        .mode_cmp(mode_cmp), .arm(arm), .disarm(disarm), .rd_addr(rd_addr),
        .rd_data(s_rd_data), .busy(s_busy), .full(s_full), .err_count(s_err),
        .first_err_valid(s_fev), .first_err_addr(s_fea)
    );

    function automatic logic [31:0] pat(input int n);
        logic [31:0] v;
        for (int k = 0; k < 8; k++) v[k*4 +: 4] = 4'((n * 7 + k * 3 + 1) % 16);
        return v;
    endfunction

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic beat(input logic [31:0] d, input logic v);
        @(negedge clk);
        lane_data  = d;
        lane_valid = v;
        @(negedge clk);
        lane_valid = 1'b0;
    endtask

    task automatic do_arm(input logic m);
        @(negedge clk);
        mode_cmp   = m;
        arm        = 1'b1;
        lane_valid = 1'b1;
        lane_data  = 32'hFFFF_FFFF;
        @(negedge clk);
        arm        = 1'b0;
        lane_valid = 1'b0;
    endtask

    task automatic rd_check(input int a, input string req);
        @(negedge clk);
        rd_addr = 10'(a);
        @(negedge clk);
        chk(req, 64'(rd_data), 64'(pat(a / 8)[(a % 8) * 4 +: 4]));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        chk("R1 busy", 64'(busy), 0);
        chk("R1 full", 64'(full), 0);
        chk("R1 err_count", 64'(err_count), 0);
        chk("R1 first_err_valid", 64'(fev), 0);

        // capture with idle cycles interleaved (R2, R4)
        do_arm(1'b0);
        chk("R9 busy after capture arm", 64'(busy), 1);
        for (int n = 0; n < 128; n++) begin
            if (n == 10 || n == 50) beat(32'hDEAD_BEEF, 1'b0);
            beat(pat(n), 1'b1);
            if (n == 126) chk("R3 still busy before last beat", 64'(busy), 1);
        end
        chk("R3 full after 128 beats", 64'(full), 1);
        chk("R3 idle after 128 beats", 64'(busy), 0);
        beat(~pat(0), 1'b1);
        rd_check(0, "R3 store unchanged after full");
        rd_check(7, "R2 lane7 of beat0");
        rd_check(8, "R2 lane0 of beat1");
        rd_check(83, "R4 address after skipped cycle");
        rd_check(8 * 51 + 6, "R4 address after second skip");
        rd_check(1023, "R2 last symbol");

        // compare pass, walked from the vector table (R5, R7, R8, R10)
        do_arm(1'b1);
        chk("R9 full cleared by arm", 64'(full), 0);
        chk("R9 err cleared and arm data ignored", 64'(err_count), 0);
        for (int i = 0; i < 8; i++) begin
            msk = VEC[i][35:4];
            inc = VEC[i][3:0];
            if (i == 2) mode_cmp = 1'b0;
            beat(pat(i) ^ msk, 1'b1);
            cum = cum + int'(inc);
            chk("R5 err_count step", 64'(err_count), 64'(cum));
            chk("R8 narrow counter saturates", 64'(s_err), 64'((cum > 15) ? 15 : cum));
            if (i == 2) begin
                chk("R7 first_err_valid", 64'(fev), 1);
                chk("R7 first_err_addr", 64'(fea), 19);
            end
        end
        chk("R10 still comparing after mode change", 64'(busy), 1);
        for (int n = 8; n < 128; n++) beat(pat(n), 1'b1);
        chk("R5 clean beats add nothing", 64'(err_count), 15);
        beat(pat(0) ^ 32'h0000_0300, 1'b1);
        chk("R6 wrap compares symbol 2", 64'(err_count), 16);
        chk("R8 narrow counter held at max", 64'(s_err), 15);
        chk("R7 first_err_addr held", 64'(fea), 19);

        @(negedge clk);
        disarm = 1'b1;
        @(negedge clk);
        disarm = 1'b0;
        chk("R6 idle after disarm", 64'(busy), 0);
        beat(32'h0F0F_0F0F, 1'b1);
        chk("R6 err held after disarm", 64'(err_count), 16);

        // re-arm restarts at symbol 0 (R9, R7)
        do_arm(1'b1);
        chk("R9 err cleared", 64'(err_count), 0);
        chk("R9 first_err cleared", 64'(fev), 0);
        beat(pat(0) ^ 32'h00F0_0000, 1'b1);
        chk("R9 restart err", 64'(err_count), 1);
        chk("R7 new first_err_addr", 64'(fea), 5);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule